// File: doc/BRIEF.md
# Period-List Playback DMA Sequencer

This block walks a table of period descriptors held in host memory and turns it into a stream of fixed-size read bursts for playback audio. Each 8-byte descriptor gives the start address of one period in its low 32-bit word. The upper 16 bits of its high word give the period length in bytes. The sequencer fetches a descriptor, then reads that period front to back in 64-byte bursts. It then moves to the next descriptor and returns to the first one after the last entry of the list.

While it runs, the block keeps a period index and a byte offset within the current period. Together these give the playback position. It signals four one-cycle events: passing the middle of a period, finishing a period, finishing the middle period of the list and finishing the last period of the list. Software sets it up through a small write-only register port and starts it with a start bit. It can be stopped cleanly by clearing that bit, or at a programmed byte offset by a stop flag.

Top module: `plist_dma_seq`

## Requirements
- R1: After reset, `curPeriod` and `bytePtr` are 0, `rdReq` is low and all four event outputs are low.
- R2: Register 2 bit 0 is the start bit. When it is set while the block is idle, the position is cleared and the first request is an 8-byte read of entry 0, at the list base address (register 0). Descriptor reads always target base + 8 × `curPeriod`.
- R3: A descriptor's period address is taken from `rspData[31:0]` and its size from `rspData[63:48]`. The first data burst of the period reads that address.
- R4: Every data request reads 64 bytes at period address + `bytePtr`. Each completed burst (a beat with `rspValid` and `rspLast`) advances `bytePtr` by 64.
- R5: When a burst brings the offset to the period size, `evFullPeriod` pulses for one cycle in the cycle after the final beat. In that same cycle `bytePtr` is 0 and `curPeriod` has advanced. The next request is the next descriptor.
- R6: `evHalfPeriod` pulses in the cycle after a burst whose old offset is below half the period size and whose new offset is at or above it.
- R7: Register 1 bits 21:16 hold the list length in bytes minus 8 (N entries give (N−1)·8). After the entry with index (field ÷ 8) completes, `curPeriod` returns to 0 and the next descriptor read targets the list base.
- R8: With N entries, `evHalfBuffer` pulses together with `evFullPeriod` when entry ⌊N/2⌋−1 completes. `evFullBuffer` pulses together with `evFullPeriod` when entry N−1 completes.
- R9: Register 3 holds an end offset in bits 15:0 and a stop flag in bit 16. With the flag at 1, a burst that brings the offset to the end offset is the last one: no request follows while the start bit stays set. With the flag at 0 the end offset has no effect.
- R10: Clearing the start bit lets the burst in flight finish. After that no new request is issued and `curPeriod` and `bytePtr` hold. Setting the bit again restarts at entry 0.
- R11: Once raised, `rdReq` stays high with a stable `rdAddr` until `rdGnt` is seen, and drops in the cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 2 | Register select: 0 list base, 1 list length, 2 start, 3 end offset and stop flag |
| cfgWdata | input | 32 | Register write data |
| rdReq | output | 1 | Memory read request |
| rdGnt | input | 1 | Memory request accepted |
| rdAddr | output | 32 | Read byte address |
| rdBytes | output | 7 | Read length in bytes (8 or 64) |
| rspValid | input | 1 | Response beat valid |
| rspLast | input | 1 | Final beat of the response |
| rspData | input | 64 | Response data; descriptor contents on descriptor reads |
| curPeriod | output | 6 | Index of the current period |
| bytePtr | output | 16 | Byte offset inside the current period |
| evHalfPeriod | output | 1 | Half-period event pulse |
| evFullPeriod | output | 1 | Period-complete event pulse |
| evHalfBuffer | output | 1 | Middle-entry-complete event pulse |
| evFullBuffer | output | 1 | Last-entry-complete event pulse |

## Verification
The half-period and full-period events share a cycle whenever a period is exactly one burst long. In that case the single burst crosses the midpoint and reaches the end together. A 64-byte period in the vector table provokes this, and the per-burst checks expect both pulses high in the same cycle. A second collision occurs when the last entry finishes: the period-end pulse, the full-buffer pulse and the wrap of `curPeriod` to 0 all happen at once. This is judged by reading both events and the position in that one cycle. The wrap is then confirmed by checking that the next descriptor read goes to the list base.

// File: rtl/plist_pkg.sv
package plist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DREQ,
    ST_DWAIT,
    ST_BREQ,
    ST_BWAIT,
    ST_HALT
  } seqState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic clearPos;   // start of a run: position back to entry 0
    logic latchDesc;  // descriptor response accepted
    logic burstDone;  // data burst response completed
    logic selDesc;    // current request is a descriptor read
  } seqStrobe_t;

  localparam logic [1:0] CFG_BASE = 2'd0;
  localparam logic [1:0] CFG_LIST = 2'd1;
  localparam logic [1:0] CFG_CTRL = 2'd2;
  localparam logic [1:0] CFG_END  = 2'd3;

endpackage

// File: rtl/plist_ctrl.sv
module plist_ctrl
  import plist_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startBit,
  input  logic       rdGnt,
  input  logic       rspValid,
  input  logic       rspLast,
  input  logic       periodDone,
  input  logic       stopHit,
  output logic       rdReq,
  output seqStrobe_t stb
);

  seqState_t state, stateNext;
  logic rspDone;

  assign rspDone = rspValid && rspLast;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (startBit) stateNext = ST_DREQ;
      ST_DREQ:  if (rdGnt) stateNext = ST_DWAIT;
      ST_DWAIT: if (rspDone) stateNext = startBit ? ST_BREQ : ST_IDLE;
      ST_BREQ:  if (rdGnt) stateNext = ST_BWAIT;
      ST_BWAIT: begin
        if (rspDone) begin
          if (stopHit)          stateNext = ST_HALT;
          else if (!startBit)   stateNext = ST_IDLE;
          else if (periodDone)  stateNext = ST_DREQ;
          else                  stateNext = ST_BREQ;
        end
      end
      ST_HALT:  if (!startBit) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    rdReq         = (state == ST_DREQ) || (state == ST_BREQ);
    stb.selDesc   = (state == ST_DREQ);
    stb.clearPos  = (state == ST_IDLE) && startBit;
    stb.latchDesc = (state == ST_DWAIT) && rspDone;
    stb.burstDone = (state == ST_BWAIT) && rspDone;
  end

endmodule

// File: rtl/plist_dpath.sv
module plist_dpath
  import plist_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned PTR_W       = 6,
  parameter int unsigned POS_W       = 16,
  parameter int unsigned BURST_BYTES = 64,
  parameter int unsigned DESC_BYTES  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfgWe,
  input  logic [1:0]                    cfgAddr,
  input  logic [31:0]                   cfgWdata,
  input  seqStrobe_t                    stb,
  input  logic [DESC_BYTES*8-1:0]       rspData,
  output logic                          startBit,
  output logic                          periodDone,
  output logic                          stopHit,
  output logic [ADDR_W-1:0]             rdAddr,
  output logic [$clog2(BURST_BYTES):0]  rdBytes,
  output logic [PTR_W-1:0]              curPeriod,
  output logic [POS_W-1:0]              bytePtr,
  output logic                          evHalfPeriod,
  output logic                          evFullPeriod,
  output logic                          evHalfBuffer,
  output logic                          evFullBuffer
);

  localparam int unsigned DATA_W     = DESC_BYTES * 8;
  localparam int unsigned WORD_W     = DATA_W / 2;
  localparam int unsigned DESC_SHIFT = $clog2(DESC_BYTES);
  localparam int unsigned IDX_W      = PTR_W - DESC_SHIFT;
  localparam int unsigned LEN_W      = $clog2(BURST_BYTES) + 1;
  localparam int unsigned LIST_LSB   = 16;

  // Configuration registers
  logic [ADDR_W-1:0] listBase;
  logic [PTR_W-1:0]  listField;
  logic [POS_W-1:0]  endOffset;
  logic              stopFlag;

  // Period state
  logic [ADDR_W-1:0] perAddr;
  logic [POS_W-1:0]  perSize;

  logic [IDX_W-1:0]  lastIdx;
  logic [IDX_W:0]    halfCount;
  logic              midValid;
  logic [IDX_W:0]    midIdx;
  logic              onLast;
  logic              onMid;
  logic [POS_W:0]    nextByte;
  logic [POS_W:0]    halfSize;
  logic              halfCross;
  logic [DATA_W-WORD_W-POS_W-1:0] unusedDescBits;

  assign unusedDescBits = rspData[DATA_W-POS_W-1:WORD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      listBase  <= '0;
      listField <= '0;
      endOffset <= '0;
      stopFlag  <= 1'b0;
      startBit  <= 1'b0;
    end else if (cfgWe) begin
      unique case (cfgAddr)
        CFG_BASE: listBase  <= ADDR_W'(cfgWdata);
        CFG_LIST: listField <= cfgWdata[LIST_LSB +: PTR_W];
        CFG_CTRL: startBit  <= cfgWdata[0];
        CFG_END: begin
          endOffset <= cfgWdata[POS_W-1:0];
          stopFlag  <= cfgWdata[POS_W];
        end
        default: ;
      endcase
    end
  end

  // List position decode
  always_comb begin
    lastIdx   = listField[PTR_W-1:DESC_SHIFT];
    halfCount = ({1'b0, lastIdx} + (IDX_W+1)'(1)) >> 1;
    midValid  = (halfCount != '0);
    midIdx    = halfCount - (IDX_W+1)'(1);
    onLast    = (curPeriod == PTR_W'(lastIdx));
    onMid     = midValid && (curPeriod == PTR_W'(midIdx));
  end

  // Byte offset arithmetic
  always_comb begin
    nextByte   = {1'b0, bytePtr} + (POS_W+1)'(BURST_BYTES);
    halfSize   = {2'b00, perSize[POS_W-1:1]};
    halfCross  = ({1'b0, bytePtr} < halfSize) && (nextByte >= halfSize);
    periodDone = (nextByte >= {1'b0, perSize});
    stopHit    = stopFlag && (nextByte == {1'b0, endOffset});
  end

  // Request address and length
  always_comb begin
    if (stb.selDesc) begin
      rdAddr  = listBase + (ADDR_W'(curPeriod) << DESC_SHIFT);
      rdBytes = LEN_W'(DESC_BYTES);
    end else begin
      rdAddr  = perAddr + ADDR_W'(bytePtr);
      rdBytes = LEN_W'(BURST_BYTES);
    end
  end

  // Position and descriptor state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curPeriod <= '0;
      bytePtr   <= '0;
      perAddr   <= '0;
      perSize   <= '0;
    end else begin
      if (stb.clearPos) begin
        curPeriod <= '0;
        bytePtr   <= '0;
      end
      if (stb.latchDesc) begin
        perAddr <= ADDR_W'(rspData[WORD_W-1:0]);
        perSize <= rspData[DATA_W-1 -: POS_W];
      end
      if (stb.burstDone) begin
        if (periodDone) begin
          bytePtr   <= '0;
          curPeriod <= onLast ? '0 : curPeriod + PTR_W'(1);
        end else begin
          bytePtr <= nextByte[POS_W-1:0];
        end
      end
    end
  end

  // Event pulses, one cycle after the completing beat
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evHalfPeriod <= 1'b0;
      evFullPeriod <= 1'b0;
      evHalfBuffer <= 1'b0;
      evFullBuffer <= 1'b0;
    end else begin
      evHalfPeriod <= stb.burstDone && halfCross;
      evFullPeriod <= stb.burstDone && periodDone;
      evHalfBuffer <= stb.burstDone && periodDone && onMid;
      evFullBuffer <= stb.burstDone && periodDone && onLast;
    end
  end

endmodule

// File: rtl/plist_dma_seq.sv
module plist_dma_seq
  import plist_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned PTR_W       = 6,
  parameter int unsigned POS_W       = 16,
  parameter int unsigned BURST_BYTES = 64,
  parameter int unsigned DESC_BYTES  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfgWe,
  input  logic [1:0]                   cfgAddr,
  input  logic [31:0]                  cfgWdata,
  output logic                         rdReq,
  input  logic                         rdGnt,
  output logic [ADDR_W-1:0]            rdAddr,
  output logic [$clog2(BURST_BYTES):0] rdBytes,
  input  logic                         rspValid,
  input  logic                         rspLast,
  input  logic [DESC_BYTES*8-1:0]      rspData,
  output logic [PTR_W-1:0]             curPeriod,
  output logic [POS_W-1:0]             bytePtr,
  output logic                         evHalfPeriod,
  output logic                         evFullPeriod,
  output logic                         evHalfBuffer,
  output logic                         evFullBuffer
);

  seqStrobe_t stb;
  logic startBit;
  logic periodDone;
  logic stopHit;

  plist_ctrl ctrlI (
    .clk        (clk),
    .rst_n      (rst_n),
    .startBit   (startBit),
    .rdGnt      (rdGnt),
    .rspValid   (rspValid),
    .rspLast    (rspLast),
    .periodDone (periodDone),
    .stopHit    (stopHit),
    .rdReq      (rdReq),
    .stb        (stb)
  );

  plist_dpath #(
    .ADDR_W      (ADDR_W),
    .PTR_W       (PTR_W),
    .POS_W       (POS_W),
    .BURST_BYTES (BURST_BYTES),
    .DESC_BYTES  (DESC_BYTES)
  ) dpathI (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfgWe        (cfgWe),
    .cfgAddr      (cfgAddr),
    .cfgWdata     (cfgWdata),
    .stb          (stb),
    .rspData      (rspData),
    .startBit     (startBit),
    .periodDone   (periodDone),
    .stopHit      (stopHit),
    .rdAddr       (rdAddr),
    .rdBytes      (rdBytes),
    .curPeriod    (curPeriod),
    .bytePtr      (bytePtr),
    .evHalfPeriod (evHalfPeriod),
    .evFullPeriod (evFullPeriod),
    .evHalfBuffer (evHalfBuffer),
    .evFullBuffer (evFullBuffer)
  );

endmodule

// File: rtl/plist_dma_seq_chk.sv
module plist_dma_seq_chk #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned PTR_W       = 6,
  parameter int unsigned POS_W       = 16,
  parameter int unsigned BURST_BYTES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rdReq,
  input logic              rdGnt,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rspValid,
  input logic              rspLast,
  input logic [PTR_W-1:0]  curPeriod,
  input logic [POS_W-1:0]  bytePtr,
  input logic              evHalfPeriod,
  input logic              evFullPeriod,
  input logic              evHalfBuffer,
  input logic              evFullBuffer
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rdReq && !rdGnt |=> rdReq && $stable(rdAddr)); // R11

  AST_EVENT_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (evHalfPeriod || evFullPeriod) |-> $past(rspValid && rspLast)); // R5

  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bytePtr) |-> (bytePtr == '0) ||
                          (bytePtr == $past(bytePtr) + POS_W'(BURST_BYTES))); // R4

  AST_PERIOD_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    evFullPeriod |-> (bytePtr == '0)); // R5

  AST_HALFBUF_ON_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    evHalfBuffer |-> evFullPeriod); // R8

  AST_FULLBUF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    evFullBuffer |-> evFullPeriod && (curPeriod == '0)); // R7

  AST_PERIOD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(curPeriod) |-> (curPeriod == '0) ||
                            (curPeriod == $past(curPeriod) + PTR_W'(1))); // R7

endmodule

bind plist_dma_seq plist_dma_seq_chk #(
  .ADDR_W      (ADDR_W),
  .PTR_W       (PTR_W),
  .POS_W       (POS_W),
  .BURST_BYTES (BURST_BYTES)
) chkI (.*);

// File: tb/plist_dma_seq_tb_top.sv
module plist_dma_seq_tb_top;

  // {entries, period bytes, expected half-buffer pulses over N+1 periods}
  localparam int unsigned VEC [4][3] = '{
    '{2, 128, 2},
    '{3,  64, 2},
    '{4, 192, 1},
    '{8,  64, 1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic        rdReq;
  logic        rdGnt = 1'b0;
  logic [31:0] rdAddr;
  logic [6:0]  rdBytes;
  logic        rspValid = 1'b0;
  logic        rspLast = 1'b0;
  logic [63:0] rspData = '0;
  logic [5:0]  curPeriod;
  logic [15:0] bytePtr;
  logic        evHalfPeriod, evFullPeriod, evHalfBuffer, evFullBuffer;

  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;

  plist_dma_seq dut_i (
    .clk (clk), .rst_n (rst_n),
    .cfgWe (cfgWe), .cfgAddr (cfgAddr), .cfgWdata (cfgWdata),
    .rdReq (rdReq), .rdGnt (rdGnt), .rdAddr (rdAddr), .rdBytes (rdBytes),
    .rspValid (rspValid), .rspLast (rspLast), .rspData (rspData),
    .curPeriod (curPeriod), .bytePtr (bytePtr),
    .evHalfPeriod (evHalfPeriod), .evFullPeriod (evFullPeriod),
    .evHalfBuffer (evHalfBuffer), .evFullBuffer (evFullBuffer)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] a, input logic [31:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic waitReq(output bit got);
    got = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (rdReq) begin
        got = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  // Serve one request; returns at the negedge where the completion results are visible
  task automatic serve(input string tag, input logic [31:0] expAddr, input logic [6:0] expBytes,
                       input logic [63:0] rdata, input int beats, input bit dropStart);
    bit got;
    logic [31:0] a0;
    waitReq(got);
    chk({tag, " request seen"}, 64'(got), 64'd1);
    if (!got) return;
    chk({tag, " address"}, 64'(rdAddr), 64'(expAddr));
    chk({tag, " length"}, 64'(rdBytes), 64'(expBytes));
    a0 = rdAddr;
    repeat (2) @(negedge clk);
    chk("R11 request held", 64'(rdReq), 64'd1);
    chk("R11 address stable", 64'(rdAddr), 64'(a0));
    rdGnt = 1'b1;
    @(negedge clk);
    rdGnt = 1'b0;
    @(negedge clk);
    chk("R11 request dropped after grant", 64'(rdReq), 64'd0);
    for (int k = 0; k < beats; k++) begin
      rspValid = 1'b1;
      rspLast  = (k == beats - 1);
      rspData  = rdata;
      if (dropStart && k == beats - 2) begin
        cfgWe = 1'b1; cfgAddr = 2'd2; cfgWdata = 32'd0;
      end
      @(negedge clk);
      cfgWe = 1'b0;
    end
    rspValid = 1'b0;
    rspLast  = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 curPeriod", 64'(curPeriod), 64'd0);
    chk("R1 bytePtr", 64'(bytePtr), 64'd0);
    chk("R1 rdReq", 64'(rdReq), 64'd0);
    chk("R1 events", 64'({evHalfPeriod, evFullPeriod, evHalfBuffer, evFullBuffer}), 64'd0);

    for (int v = 0; v < 4; v++) begin
      automatic int unsigned n  = VEC[v][0];
      automatic int unsigned sz = VEC[v][1];
      automatic logic [31:0] base = 32'h0000_8000 + 32'(v) * 32'h100;
      automatic int hbCnt = 0;
      automatic int fpCnt = 0;
      automatic int fbCnt = 0;
      automatic int unsigned lastP = 0;
      automatic int unsigned lastB = 0;
      automatic bit sawReq = 1'b0;
      cfgWrite(2'd0, base);
      cfgWrite(2'd1, ((n - 1) * 8) << 16);
      cfgWrite(2'd3, 32'h0000_0040);       // stop flag clear: end offset ignored (R9)
      cfgWrite(2'd2, 32'd1);                // start from entry 0 (R2, R10)
      for (int q = 0; q <= int'(n); q++) begin
        automatic int unsigned p = 32'(q) % n;
        automatic logic [31:0] pa = 32'h0040_0000 + p * 32'h0001_0000;
        serve((q == int'(n)) ? "R7 wrap descriptor" : "R2 descriptor",
              base + p * 8, 7'd8, {sz[15:0], 16'h0000, pa}, 1, 1'b0);
        for (int unsigned b = 0; b < sz; b += 64) begin
          automatic int unsigned nb = b + 64;
          automatic bit last = (q == int'(n)) && (nb >= sz);
          automatic bit eHalf = (b < sz / 2) && (nb >= sz / 2);
          automatic bit eFull = (nb >= sz);
          automatic bit eHb = eFull && (p == n / 2 - 1);
          automatic bit eFb = eFull && (p == n - 1);
          serve("R3 R4 data burst", pa + b, 7'd64, 64'h0, 2, last);
          chk("R6 half-period event", 64'(evHalfPeriod), 64'(eHalf));
          chk("R5 full-period event", 64'(evFullPeriod), 64'(eFull));
          chk("R8 half-buffer event", 64'(evHalfBuffer), 64'(eHb));
          chk("R8 full-buffer event", 64'(evFullBuffer), 64'(eFb));
          lastB = eFull ? 0 : nb;
          lastP = eFull ? ((p == n - 1) ? 0 : p + 1) : p;
          chk("R4 R5 bytePtr", 64'(bytePtr), 64'(lastB));
          chk("R5 R7 curPeriod", 64'(curPeriod), 64'(lastP));
          hbCnt += int'(evHalfBuffer);
          fpCnt += int'(evFullPeriod);
          fbCnt += int'(evFullBuffer);
        end
      end
      // start was cleared during the final burst
      repeat (8) begin
        @(negedge clk);
        if (rdReq) sawReq = 1'b1;
      end
      chk("R10 no request after start cleared", 64'(sawReq), 64'd0);
      chk("R10 curPeriod held", 64'(curPeriod), 64'(lastP));
      chk("R10 bytePtr held", 64'(bytePtr), 64'(lastB));
      chk("R8 half-buffer count", 64'(hbCnt), 64'(VEC[v][2]));
      chk("R5 full-period count", 64'(fpCnt), 64'(n + 1));
      chk("R8 full-buffer count", 64'(fbCnt), 64'd1);
    end

    // Directed: stop flag halts at end offset 128 of a 256-byte period
    begin
      automatic bit sawReq = 1'b0;
      cfgWrite(2'd0, 32'h0000_9000);
      cfgWrite(2'd1, 32'h0008_0000);
      cfgWrite(2'd3, 32'h0001_0080);
      cfgWrite(2'd2, 32'd1);
      serve("R2 descriptor", 32'h0000_9000, 7'd8, {16'h0100, 16'h0000, 32'h0050_0000}, 1, 1'b0);
      serve("R4 data burst", 32'h0050_0000, 7'd64, 64'h0, 2, 1'b0);
      chk("R4 bytePtr after first burst", 64'(bytePtr), 64'd64);
      chk("R6 no half event below midpoint", 64'(evHalfPeriod), 64'd0);
      serve("R4 data burst", 32'h0050_0040, 7'd64, 64'h0, 2, 1'b0);
      chk("R6 half event at midpoint", 64'(evHalfPeriod), 64'd1);
      chk("R9 bytePtr at end offset", 64'(bytePtr), 64'd128);
      repeat (10) begin
        @(negedge clk);
        if (rdReq) sawReq = 1'b1;
      end
      chk("R9 no request after stop offset", 64'(sawReq), 64'd0);
      chk("R9 bytePtr holds", 64'(bytePtr), 64'd128);
      cfgWrite(2'd2, 32'd0);
      cfgWrite(2'd3, 32'd0);
      @(negedge clk);
      cfgWrite(2'd2, 32'd1);
      @(negedge clk);
      chk("R10 restart clears bytePtr", 64'(bytePtr), 64'd0);
      serve("R10 restart descriptor", 32'h0000_9000, 7'd8, {16'h0100, 16'h0000, 32'h0050_0000}, 1, 1'b0);
      chk("R10 restart curPeriod", 64'(curPeriod), 64'd0);
    end

    finishRun();
  end

endmodule